// File: doc/BRIEF.md
# Address-Translation Status and Control Register Set

This block holds the software-visible state that surrounds a memory address translator. It keeps four registers and three auxiliary ones. The status word records enable and error state. The undo log records register auto-increment and auto-decrement steps so that a faulted instruction can be rolled back. The virtual-PC word and the control word are plain loadable registers, and three auxiliary words (CPU error, program interrupt request, control/status) also load directly.

Software writes to the status word are filtered. Two bit positions are reserved and always read as zero. Enabling translation wipes the error field. Once any error bit is set, a write that leaves translation disabled keeps only its low mode bits, which protects the recorded state. The translation logic can also set or clear single status bits through dedicated strobes.

The undo log is a two-entry shift register of 8-bit records. Each record packs a sign-extended step and a register number. A per-run-mode data-space enable is decoded from the control word.

Top module: `xlat_regs`

## Requirements
- R1: After synchronous reset every register output and `log_ovf` read as zero.
- R2: Status bits 11 and 10 always read 0. Software writes and hardware set strobes aimed at them have no effect.
- R3: A status write (`wr_sel`=0) with data bit 0 set stores the data with bits 15..13 and 11..10 forced to 0.
- R4: A status write with data bit 0 clear, made while any current status bit 15..13 is 1, stores only data bits 7..1. All other bits are stored as 0.
- R5: A status write with data bit 0 clear, made while status bits 15..13 are all 0, stores the data with only bits 11..10 forced to 0.
- R6: `bit_clr_en` clears status bit `bit_clr_idx` and `bit_set_en` sets bit `bit_set_idx`. Both act after a same-cycle software write, and the set strobe wins over the clear strobe on the same bit.
- R7: An accepted log request makes the new log value equal to (old << 8), with the 5-bit sign-extended step in bits 7..3 and the register number in bits 2..0, truncated to 16 bits.
- R8: A log request is ignored, and `log_ovf` becomes 1, in three cases: any status bit 15..13 is 1, the step is outside -2..+2 (3-bit two's complement), or the log value before the shift is 256 or more. `log_ovf` stays 1 until reset.
- R9: `log_clr` zeroes the log. An accepted request in the same cycle lands on the cleared log, so the log holds only the new record and the full test does not apply.
- R10: A write with `wr_sel` 1, 2, 3, 4 or 5 loads the virtual-PC, control, CPU-error, interrupt-request or control/status word respectively. Selects 6 and 7 change nothing, and no write alters any register other than the selected one.
- R11: `dspace_en` equals control bit 2 for `run_mode` 0, bit 1 for mode 1, bit 0 for mode 3, and is 0 for mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| bit_set_en | input | 1 | Hardware status bit set strobe |
| bit_set_idx | input | 4 | Status bit to set |
| bit_clr_en | input | 1 | Hardware status bit clear strobe |
| bit_clr_idx | input | 4 | Status bit to clear |
| log_en | input | 1 | Undo log append request |
| log_clr | input | 1 | Undo log clear |
| log_delta | input | 3 | Signed register step |
| log_regn | input | 3 | Register number |
| run_mode | input | 2 | Current run mode |
| stat_q | output | 16 | Status word |
| undo_q | output | 16 | Undo log |
| vpc_q | output | 16 | Virtual-PC word |
| ctl_q | output | 16 | Control word |
| err_q | output | 16 | CPU error word |
| pir_q | output | 16 | Interrupt request word |
| csr_q | output | 16 | Control/status word |
| dspace_en | output | 1 | Data-space enable for `run_mode` |
| log_ovf | output | 1 | Sticky rejected-log flag |

## Verification
Two pairs of functions can collide in one cycle. A software status write can coincide with the hardware set and clear strobes. A log clear can coincide with a log append, including while the log is full or the status word is locked. The bench provokes each pair in dedicated steps. It drives the set and clear strobes onto the same bit and onto a bit being written, and it fires clear plus append against a full log and against a locked status word. An arithmetic model of the register rules gives the expected value for every step.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int REG_W       = 16;
    localparam int IDX_W       = $clog2(REG_W);
    localparam int SEL_W       = 3;
    localparam int STEP_W      = 3;
    localparam int REC_STEP_W  = 5;
    localparam int REGNUM_W    = 3;
    localparam int REC_W       = REC_STEP_W + REGNUM_W;
    localparam int MODE_W      = 2;
    localparam int N_AUX       = 3;

    localparam logic [REG_W-1:0] RSVD_MASK  = 16'h0C00;
    localparam logic [REG_W-1:0] ERR_MASK   = 16'hE000;
    localparam logic [REG_W-1:0] KEEP_LOCK  = 16'h00FE;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT = 3'd0,
        SEL_VPC  = 3'd1,
        SEL_CTL  = 3'd2,
        SEL_ERR  = 3'd3,
        SEL_PIR  = 3'd4,
        SEL_CSR  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic                       en;
        logic                       clr;
        logic signed [STEP_W-1:0]   step;
        logic [REGNUM_W-1:0]        regn;
    } log_req_t;

    typedef struct packed {
        logic                       set_en;
        logic [IDX_W-1:0]           set_idx;
        logic                       clr_en;
        logic [IDX_W-1:0]           clr_idx;
    } bit_op_t;

    // Filtered result of a software write to the status word.
    function automatic logic [REG_W-1:0] stat_sw_write(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] wd
    );
        logic [REG_W-1:0] v;
        v = wd & ~RSVD_MASK;
        if (v[0])
            v = v & ~ERR_MASK;
        else if ((cur & ERR_MASK) != '0)
            v = v & KEEP_LOCK;
        return v;
    endfunction

    // One-hot mask for a hardware bit strobe, reserved positions removed.
    function automatic logic [REG_W-1:0] stat_bit_mask(input logic [IDX_W-1:0] idx);
        logic [REG_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m & ~RSVD_MASK;
    endfunction

    function automatic logic step_in_range(input logic signed [STEP_W-1:0] s);
        return (s >= -3'sd2) && (s <= 3'sd2);
    endfunction

    function automatic logic [REC_W-1:0] make_record(
        input logic signed [STEP_W-1:0] s,
        input logic [REGNUM_W-1:0]      r
    );
        logic [REC_STEP_W-1:0] se;
        se = {{(REC_STEP_W-STEP_W){s[STEP_W-1]}}, s};
        return {se, r};
    endfunction

endpackage

// File: rtl/xlat_stat_reg.sv
module xlat_stat_reg
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  bit_op_t          bop,
    output logic [REG_W-1:0] stat_q,
    output logic             locked
);

    logic [REG_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (wr_stb)
            stat_d = stat_sw_write(stat_q, wr_data);
        if (bop.clr_en)
            stat_d = stat_d & ~stat_bit_mask(bop.clr_idx);
        if (bop.set_en)
            stat_d = stat_d | stat_bit_mask(bop.set_idx);
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    assign locked = (stat_q & ERR_MASK) != '0;

endmodule

// File: rtl/xlat_undo_log.sv
module xlat_undo_log
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  log_req_t         req,
    input  logic             locked,
    output logic [REG_W-1:0] log_q,
    output logic             ovf_q
);

    logic             full;
    logic             accept;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] log_d;

    assign full   = log_q[REG_W-1:REC_W] != '0;
    assign accept = req.en && step_in_range(req.step) && !locked
                    && (req.clr || !full);
    assign base   = req.clr ? '0 : log_q;

    always_comb begin
        log_d = base;
        if (accept)
            log_d = {base[REG_W-REC_W-1:0], make_record(req.step, req.regn)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            log_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            log_q <= log_d;
            if (req.en && !accept)
                ovf_q <= 1'b1;
        end
    end

endmodule

// File: rtl/xlat_dspace_sel.sv
module xlat_dspace_sel
    import xlat_pkg::*;
(
    input  logic [2:0]        ctl_bits,
    input  logic [MODE_W-1:0] mode,
    output logic              ds_en
);

    always_comb begin
        case (mode)
            2'd0:    ds_en = ctl_bits[2];
            2'd1:    ds_en = ctl_bits[1];
            2'd3:    ds_en = ctl_bits[0];
            default: ds_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                bit_set_en,
    input  logic [IDX_W-1:0]    bit_set_idx,
    input  logic                bit_clr_en,
    input  logic [IDX_W-1:0]    bit_clr_idx,
    input  logic                log_en,
    input  logic                log_clr,
    input  logic [STEP_W-1:0]   log_delta,
    input  logic [REGNUM_W-1:0] log_regn,
    input  logic [MODE_W-1:0]   run_mode,
    output logic [REG_W-1:0]    stat_q,
    output logic [REG_W-1:0]    undo_q,
    output logic [REG_W-1:0]    vpc_q,
    output logic [REG_W-1:0]    ctl_q,
    output logic [REG_W-1:0]    err_q,
    output logic [REG_W-1:0]    pir_q,
    output logic [REG_W-1:0]    csr_q,
    output logic                dspace_en,
    output logic                log_ovf
);

    localparam logic [SEL_W-1:0] AUX_SEL [N_AUX] = '{SEL_ERR, SEL_PIR, SEL_CSR};

    bit_op_t          bop;
    log_req_t         lreq;
    logic             locked;
    logic [REG_W-1:0] aux_q [N_AUX];

    assign bop  = '{set_en: bit_set_en, set_idx: bit_set_idx,
                    clr_en: bit_clr_en, clr_idx: bit_clr_idx};
    assign lreq = '{en: log_en, clr: log_clr,
                    step: $signed(log_delta), regn: log_regn};

    xlat_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_en && (wr_sel == SEL_STAT)),
        .wr_data (wr_data),
        .bop     (bop),
        .stat_q  (stat_q),
        .locked  (locked)
    );

    xlat_undo_log u_log (
        .clk    (clk),
        .rst    (rst),
        .req    (lreq),
        .locked (locked),
        .log_q  (undo_q),
        .ovf_q  (log_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpc_q <= '0;
            ctl_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_VPC) vpc_q <= wr_data;
            if (wr_sel == SEL_CTL) ctl_q <= wr_data;
        end
    end

    for (genvar g = 0; g < N_AUX; g++) begin : g_aux
        always_ff @(posedge clk) begin
            if (rst)
                aux_q[g] <= '0;
            else if (wr_en && (wr_sel == AUX_SEL[g]))
                aux_q[g] <= wr_data;
        end
    end

    assign err_q = aux_q[0];
    assign pir_q = aux_q[1];
    assign csr_q = aux_q[2];

    xlat_dspace_sel u_ds (
        .ctl_bits (ctl_q[2:0]),
        .mode     (run_mode),
        .ds_en    (dspace_en)
    );

endmodule

// File: rtl/xlat_regs_chk.sv
module xlat_regs_chk
    import xlat_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [SEL_W-1:0]    wr_sel,
    input logic [REG_W-1:0]    wr_data,
    input logic                bit_set_en,
    input logic                bit_clr_en,
    input logic                log_en,
    input logic                log_clr,
    input logic [MODE_W-1:0]   run_mode,
    input logic [REG_W-1:0]    stat_q,
    input logic [REG_W-1:0]    undo_q,
    input logic [REG_W-1:0]    vpc_q,
    input logic                dspace_en,
    input logic                log_ovf
);

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        stat_q[11:10] == 2'b00);

    a_r3_enable_wipes: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_STAT && wr_data[0] && !bit_set_en)
        |=> stat_q[15:13] == 3'b000);

    a_r4_lock_keep: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_STAT && !wr_data[0] && stat_q[15:13] != 3'b000
         && !bit_set_en && !bit_clr_en)
        |=> stat_q == ($past(wr_data) & 16'h00FE));

    a_r8_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (stat_q[15:13] != 3'b000 && !log_clr) |=> $stable(undo_q));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        log_ovf |=> log_ovf);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (log_clr && !log_en) |=> undo_q == '0);

    a_r10_vpc_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_VPC) |=> vpc_q == $past(wr_data));

    a_r11_mode2_off: assert property (@(posedge clk) disable iff (rst)
        (run_mode == 2'd2) |-> !dspace_en);

endmodule

bind xlat_regs xlat_regs_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .bit_set_en (bit_set_en),
    .bit_clr_en (bit_clr_en),
    .log_en     (log_en),
    .log_clr    (log_clr),
    .run_mode   (run_mode),
    .stat_q     (stat_q),
    .undo_q     (undo_q),
    .vpc_q      (vpc_q),
    .dspace_en  (dspace_en),
    .log_ovf    (log_ovf)
);

// File: tb/test_xlat_regs.sv
module test_xlat_regs;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        bit_set_en;
    logic [3:0]  bit_set_idx;
    logic        bit_clr_en;
    logic [3:0]  bit_clr_idx;
    logic        log_en;
    logic        log_clr;
    logic [2:0]  log_delta;
    logic [2:0]  log_regn;
    logic [1:0]  run_mode;
    logic [15:0] stat_q, undo_q, vpc_q, ctl_q, err_q, pir_q, csr_q;
    logic        dspace_en, log_ovf;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] m_stat, m_log, m_vpc, m_ctl, m_err, m_pir, m_csr;
    logic        m_ovf;

    always #2 clk = ~clk;

    xlat_regs i_xlat_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bit_set_en(bit_set_en), .bit_set_idx(bit_set_idx),
        .bit_clr_en(bit_clr_en), .bit_clr_idx(bit_clr_idx),
        .log_en(log_en), .log_clr(log_clr), .log_delta(log_delta), .log_regn(log_regn),
        .run_mode(run_mode), .stat_q(stat_q), .undo_q(undo_q), .vpc_q(vpc_q),
        .ctl_q(ctl_q), .err_q(err_q), .pir_q(pir_q), .csr_q(csr_q),
        .dspace_en(dspace_en), .log_ovf(log_ovf)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_ds(logic [15:0] c, logic [1:0] m);
        if (m == 2'd0) return c[2];
        if (m == 2'd1) return c[1];
        if (m == 2'd3) return c[0];
        return 1'b0;
    endfunction

    task automatic cmp_all(string tag);
        chk(tag, "stat", stat_q, m_stat);
        chk(tag, "undo", undo_q, m_log);
        chk(tag, "vpc",  vpc_q,  m_vpc);
        chk(tag, "ctl",  ctl_q,  m_ctl);
        chk(tag, "err",  err_q,  m_err);
        chk(tag, "pir",  pir_q,  m_pir);
        chk(tag, "csr",  csr_q,  m_csr);
        chk(tag, "ovf",  {15'd0, log_ovf},   {15'd0, m_ovf});
        chk(tag, "dspace", {15'd0, dspace_en}, {15'd0, exp_ds(m_ctl, run_mode)});
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0;
        bit_set_en = 0; bit_set_idx = 0; bit_clr_en = 0; bit_clr_idx = 0;
        log_en = 0; log_clr = 0; log_delta = 0; log_regn = 0;
    endtask

    // Advance one clock, updating the model from the requirement rules.
    task automatic step(string tag);
        logic [15:0] v;
        logic [15:0] b;
        int d;
        logic ok;
        v = m_stat;
        if (wr_en && wr_sel == 3'd0) begin
            v = wr_data & 16'hF3FF;                        // R2
            if (v[0]) v = v & 16'h1FFF;                    // R3
            else if (m_stat[15:13] != 0) v = v & 16'h00FE; // R4
        end
        if (bit_clr_en && bit_clr_idx != 10 && bit_clr_idx != 11) v[bit_clr_idx] = 1'b0;
        if (bit_set_en && bit_set_idx != 10 && bit_set_idx != 11) v[bit_set_idx] = 1'b1;
        d  = $signed(log_delta);
        ok = log_en && d >= -2 && d <= 2 && m_stat[15:13] == 0 && (log_clr || m_log < 256);
        b  = log_clr ? 16'h0 : m_log;
        if (ok) b = (b << 8) | {8'h0, log_delta[2], log_delta[2], log_delta, log_regn};
        if (log_en && !ok) m_ovf = 1'b1;
        m_log = b;
        if (wr_en) begin
            case (wr_sel)
                3'd1: m_vpc = wr_data;
                3'd2: m_ctl = wr_data;
                3'd3: m_err = wr_data;
                3'd4: m_pir = wr_data;
                3'd5: m_csr = wr_data;
                default: ;
            endcase
        end
        m_stat = v;
        @(posedge clk);
        @(negedge clk);
        cmp_all(tag);
        idle();
    endtask

    task automatic sw_wr(logic [2:0] s, logic [15:0] d, string tag);
        wr_en = 1; wr_sel = s; wr_data = d;
        step(tag);
    endtask

    task automatic hw_set(int b, string tag);
        bit_set_en = 1; bit_set_idx = b[3:0];
        step(tag);
    endtask

    task automatic log_add(int d, int r, logic clr, string tag);
        log_en = 1; log_clr = clr; log_delta = d[2:0]; log_regn = r[2:0];
        step(tag);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        run_mode = 0;
        rst = 1;
        m_stat = 0; m_log = 0; m_vpc = 0; m_ctl = 0;
        m_err = 0; m_pir = 0; m_csr = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cmp_all("R1");

        // R3 R4 R5 R2: status writes for every error-bit preset
        for (int pre = 0; pre < 8; pre++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] p;
                sw_wr(3'd0, 16'h0001, "R3");
                sw_wr(3'd0, 16'h0000, "R5");
                for (int e = 0; e < 3; e++)
                    if (pre[e]) hw_set(13 + e, "R6");
                p = 16'hA5C3 ^ (16'(k) * 16'h1111);
                p[0] = k[0];
                sw_wr(3'd0, p, pre == 0 ? "R5" : (k[0] ? "R3" : "R4"));
                sw_wr(3'd0, 16'hFFFE, "R2");
            end
        end

        // R6 R2: single-bit strobes and their collisions
        for (int b = 0; b < 16; b++) begin
            sw_wr(3'd0, 16'h0001, "R3");
            hw_set(b, b == 10 || b == 11 ? "R2" : "R6");
            bit_clr_en = 1; bit_clr_idx = b[3:0];
            step("R6");
            bit_set_en = 1; bit_set_idx = b[3:0]; bit_clr_en = 1; bit_clr_idx = b[3:0];
            step("R6");
            wr_en = 1; wr_sel = 3'd0; wr_data = 16'h0001;
            bit_set_en = 1; bit_set_idx = 4'(15 - b);
            bit_clr_en = 1; bit_clr_idx = 4'd0;
            step("R6");
        end

        // R7 R8 R9: undo log sweep over every step and register
        sw_wr(3'd0, 16'h0001, "R3");
        sw_wr(3'd0, 16'h0000, "R5");
        for (int d = -4; d < 4; d++) begin
            for (int r = 0; r < 8; r++) begin
                log_clr = 1;
                step("R9");
                log_add(d, r, 1'b0, (d < -2 || d > 2) ? "R8" : "R7");
                log_add(1, 7 - r, 1'b0, "R7");
                log_add(-1, r, 1'b0, "R8");
                log_add(2, r, 1'b1, "R9");
            end
        end
        for (int b = 13; b < 16; b++) begin
            log_clr = 1;
            step("R9");
            log_add(-2, 5, 1'b0, "R7");
            hw_set(b, "R6");
            log_add(1, 3, 1'b0, "R8");
            log_add(1, 3, 1'b1, "R8");
            sw_wr(3'd0, 16'h0001, "R3");
            log_add(-2, 6, 1'b0, "R7");
        end

        // R10: every write select, including the unused ones
        for (int s = 0; s < 8; s++) begin
            sw_wr(3'(s), 16'h1357 + 16'(s * 16'h0F0F), "R10");
            sw_wr(3'(s), 16'hFFFE - 16'(s), "R10");
        end

        // R11: all control patterns against all run modes
        for (int c = 0; c < 8; c++) begin
            sw_wr(3'd2, 16'hFFF8 | 16'(c), "R10");
            for (int m = 0; m < 4; m++) begin
                run_mode = 2'(m);
                #1;
                chk("R11", "dspace", {15'd0, dspace_en}, {15'd0, exp_ds(m_ctl, run_mode)});
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule